// File: doc/BRIEF.md
# CAN Node Fault Confinement Unit

This block tracks how healthy a CAN node is. It keeps two saturating counters, one for transmit errors and one for receive errors. From them it works out whether the node may take full part on the bus, must take a reduced part, or must stay off the bus altogether. The protocol engine reports each frame outcome as a single-cycle event pulse. The unit returns the node state, both counter values, the polarity to use for the next error flag, and a request to hold off the next transmission.

Once the node is disconnected, the block stops counting events. It then watches the bus through a bit strobe that carries the sampled level. It reconnects the node only after a fixed number of long recessive runs has been seen. A node with reduced rights gets a quiet gap of a few bit times after each transmission it ends. During that gap other nodes can claim the bus first.

Top module: `can_fault_conf`

## Requirements
- R1: After reset, state_o is 0 (full participation), tec_o and rec_o are 0, suspend_o is 0 and flag_recessive_o is 0.
- R2: Each tx_err_i pulse adds 8 to tec_o. Each tx_ok_i pulse subtracts 1, and the count never goes below 0. When both arrive in the same cycle, the addition wins.
- R3: An rx_err_i pulse adds 1 to rec_o. An rx_err_first_i pulse adds 8, and it wins over rx_err_i in the same cycle. An rx_ok_i pulse subtracts 1, and the count never goes below 0.
- R4: state_o is 1 (reduced participation) while either counter is 128 or more and the node is not disconnected. It returns to 0 as soon as both counters are below 128.
- R5: state_o becomes 2 (disconnected) when tec_o reaches 256 or more. While state_o is 2, all counter events are ignored and both counters hold their values.
- R6: flag_recessive_o is 0 when state_o is 0 and 1 otherwise. This selects a dominant or a recessive error flag.
- R7: While disconnected, the unit counts bit strobes with bus_rec_i high. The strobe that completes the 128th run of 11 consecutive recessive bits returns state_o to 0 and clears both counters. The disconnected state has no other exit.
- R8: During recovery, a bit strobe with bus_rec_i low restarts the current 11-bit run. Runs already completed are kept.
- R9: A tx_ok_i or tx_err_i pulse seen while state_o is 1 raises suspend_o for the next 8 bit strobes. The same pulses in state 0 leave suspend_o at 0. suspend_o is forced to 0 while disconnected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_err_i | input | 1 | Pulse: own transmission failed |
| tx_ok_i | input | 1 | Pulse: own transmission succeeded |
| rx_err_i | input | 1 | Pulse: receive error |
| rx_err_first_i | input | 1 | Pulse: receive error that this node detected first |
| rx_ok_i | input | 1 | Pulse: frame received correctly |
| bit_tick_i | input | 1 | Strobe: one bit time elapsed, with the level sampled |
| bus_rec_i | input | 1 | Sampled bus level at bit_tick_i, 1 = recessive |
| state_o | output | 2 | 0 full, 1 reduced, 2 disconnected |
| tec_o | output | 9 | Transmit error counter |
| rec_o | output | 9 | Receive error counter |
| flag_recessive_o | output | 1 | 1 = send the error flag as recessive bits |
| suspend_o | output | 1 | Hold off the next transmission |

## Verification
The counters are driven by plain error bursts, by simultaneous error and success pulses, and by decrements below zero. These patterns separate the step sizes, the priority rule and the floor at zero. The threshold is crossed at exactly 128 in both directions, once on each counter, which shows that either counter alone moves the state. Recovery gets a broken first run followed by exactly one strobe short of the full count, and then the final strobe. This exposes an off-by-one in the run length, in the run count, or in the restart on a dominant bit. Suspension is started in the reduced state and in the full state, and again on the transition into disconnection.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'd0,
    FC_PASSIVE = 2'd1,
    FC_BUSOFF  = 2'd2
  } fc_state_e;
endpackage

// File: rtl/fc_err_counter.sv
module fc_err_counter #(
  parameter int CNT_W    = 9,
  parameter int BIG_STEP = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             hold_i,
  input  logic             inc_big_i,
  input  logic             inc_small_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   sum;
  logic [CNT_W:0]   step;

  always_comb begin
    step = '0;
    if (inc_big_i)        step = (CNT_W+1)'(BIG_STEP);
    else if (inc_small_i) step = (CNT_W+1)'(1);
    sum = {1'b0, cnt_q} + step;
    cnt_d = cnt_q;
    if (inc_big_i || inc_small_i) cnt_d = sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
    else if (dec_i && cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (!hold_i) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/fc_busoff_ctrl.sv
module fc_busoff_ctrl #(
  parameter int CNT_W      = 9,
  parameter int BUSOFF_LIM = 256,
  parameter int RUN_LEN    = 11,
  parameter int RUN_NUM    = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] tec_i,
  input  logic             bit_tick_i,
  input  logic             bus_rec_i,
  output logic             busoff_o,
  output logic             recover_o
);
  localparam int RW = (RUN_LEN > 2) ? $clog2(RUN_LEN) : 1;
  localparam int OW = (RUN_NUM > 2) ? $clog2(RUN_NUM) : 1;
  localparam logic [CNT_W-1:0] OFF_LIM  = CNT_W'(BUSOFF_LIM);
  localparam logic [RW-1:0]    RUN_LAST = RW'(RUN_LEN - 1);
  localparam logic [OW-1:0]    OCC_LAST = OW'(RUN_NUM - 1);

  logic          off_q;
  logic [RW-1:0] run_q;
  logic [OW-1:0] occ_q;
  logic          run_done;

  // tec crossing the limit disconnects at once; the register keeps it off
  assign busoff_o  = off_q || (tec_i >= OFF_LIM);
  assign run_done  = bit_tick_i && bus_rec_i && (run_q == RUN_LAST);
  assign recover_o = off_q && run_done && (occ_q == OCC_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q <= 1'b0;
      run_q <= '0;
      occ_q <= '0;
    end else if (!off_q) begin
      off_q <= (tec_i >= OFF_LIM);
      run_q <= '0;
      occ_q <= '0;
    end else if (bit_tick_i) begin
      if (!bus_rec_i) begin
        run_q <= '0;
      end else if (run_done) begin
        run_q <= '0;
        if (occ_q == OCC_LAST) begin
          occ_q <= '0;
          off_q <= 1'b0;
        end else begin
          occ_q <= occ_q + 1'b1;
        end
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fc_suspend_timer.sv
module fc_suspend_timer #(
  parameter int SUSP_LEN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic start_i,
  input  logic bit_tick_i,
  output logic active_o
);
  localparam int TW = $clog2(SUSP_LEN + 1);

  logic [TW-1:0] tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        tmr_q <= '0;
    else if (clr_i)                     tmr_q <= '0;
    else if (start_i)                   tmr_q <= TW'(SUSP_LEN);
    else if (bit_tick_i && tmr_q != '0) tmr_q <= tmr_q - 1'b1;
  end

  assign active_o = (tmr_q != '0);
endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf
  import can_fc_pkg::*;
#(
  parameter int CNT_W       = 9,
  parameter int PASSIVE_LIM = 128,
  parameter int BUSOFF_LIM  = 256,
  parameter int BIG_STEP    = 8,
  parameter int RUN_LEN     = 11,
  parameter int RUN_NUM     = 128,
  parameter int SUSP_LEN    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_err_i,
  input  logic             tx_ok_i,
  input  logic             rx_err_i,
  input  logic             rx_err_first_i,
  input  logic             rx_ok_i,
  input  logic             bit_tick_i,
  input  logic             bus_rec_i,
  output logic [1:0]       state_o,
  output logic [CNT_W-1:0] tec_o,
  output logic [CNT_W-1:0] rec_o,
  output logic             flag_recessive_o,
  output logic             suspend_o
);
  localparam logic [CNT_W-1:0] PAS_LIM = CNT_W'(PASSIVE_LIM);

  logic      busoff, recover, susp_run, susp_start;
  fc_state_e state;

  fc_err_counter #(.CNT_W(CNT_W), .BIG_STEP(BIG_STEP)) u_tec (
    .clk_i, .rst_ni,
    .clr_i      (recover),
    .hold_i     (busoff),
    .inc_big_i  (tx_err_i),
    .inc_small_i(1'b0),
    .dec_i      (tx_ok_i),
    .cnt_o      (tec_o)
  );

  fc_err_counter #(.CNT_W(CNT_W), .BIG_STEP(BIG_STEP)) u_rec (
    .clk_i, .rst_ni,
    .clr_i      (recover),
    .hold_i     (busoff),
    .inc_big_i  (rx_err_first_i),
    .inc_small_i(rx_err_i),
    .dec_i      (rx_ok_i),
    .cnt_o      (rec_o)
  );

  fc_busoff_ctrl #(
    .CNT_W(CNT_W), .BUSOFF_LIM(BUSOFF_LIM), .RUN_LEN(RUN_LEN), .RUN_NUM(RUN_NUM)
  ) u_boff (
    .clk_i, .rst_ni,
    .tec_i     (tec_o),
    .bit_tick_i,
    .bus_rec_i,
    .busoff_o  (busoff),
    .recover_o (recover)
  );

  always_comb begin
    if (busoff)                                   state = FC_BUSOFF;
    else if (tec_o >= PAS_LIM || rec_o >= PAS_LIM) state = FC_PASSIVE;
    else                                          state = FC_ACTIVE;
  end

  assign susp_start = (state == FC_PASSIVE) && (tx_ok_i || tx_err_i);

  fc_suspend_timer #(.SUSP_LEN(SUSP_LEN)) u_susp (
    .clk_i, .rst_ni,
    .clr_i     (busoff),
    .start_i   (susp_start),
    .bit_tick_i,
    .active_o  (susp_run)
  );

  assign state_o          = state;
  assign flag_recessive_o = (state != FC_ACTIVE);
  assign suspend_o        = susp_run && !busoff;
endmodule

// File: rtl/fc_chk.sv
module fc_chk
  import can_fc_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tx_err_i,
  input logic [1:0]       state_o,
  input logic [CNT_W-1:0] tec_o,
  input logic [CNT_W-1:0] rec_o,
  input logic             flag_recessive_o,
  input logic             suspend_o
);
  // R2
  tec_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_err_i && state_o != FC_BUSOFF && tec_o <= CNT_W'(247)) |=> tec_o == $past(tec_o) + CNT_W'(8));

  // R4
  passive_lim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != FC_BUSOFF) |-> ((state_o == FC_PASSIVE) == (tec_o >= CNT_W'(128) || rec_o >= CNT_W'(128))));

  // R5
  busoff_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == FC_BUSOFF) |=> (state_o == FC_ACTIVE) || ($stable(tec_o) && $stable(rec_o)));

  // R6
  flag_pol_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == FC_ACTIVE) |-> !flag_recessive_o);

  // R7
  busoff_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == FC_BUSOFF) |=> (state_o != FC_PASSIVE));

  // R7
  recover_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_o) == FC_BUSOFF && state_o == FC_ACTIVE) |-> (tec_o == '0 && rec_o == '0));

  // R9
  susp_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(suspend_o) |-> $past(state_o) == FC_PASSIVE);
endmodule

bind can_fault_conf fc_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tx_err_i(tx_err_i), .state_o(state_o),
  .tec_o(tec_o), .rec_o(rec_o), .flag_recessive_o(flag_recessive_o),
  .suspend_o(suspend_o)
);

// File: tb/can_fault_conf_tb.sv
module can_fault_conf_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_err = 0, tx_ok = 0, rx_err = 0, rx_first = 0, rx_ok = 0;
  logic       tick = 0, brec = 1;
  logic [1:0] state;
  logic [8:0] tec, rec;
  logic       flag_rec, susp;
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;

  always #5 clk = ~clk;

  can_fault_conf u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tx_err_i(tx_err), .tx_ok_i(tx_ok),
    .rx_err_i(rx_err), .rx_err_first_i(rx_first), .rx_ok_i(rx_ok),
    .bit_tick_i(tick), .bus_rec_i(brec), .state_o(state), .tec_o(tec),
    .rec_o(rec), .flag_recessive_o(flag_rec), .suspend_o(susp)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
  endtask

  // kind: 0 tx_err, 1 tx_ok, 2 rx_err, 3 rx_first, 4 rx_ok, 5 tx_err+tx_ok
  task automatic pulse(int kind, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tx_err   = (kind == 0 || kind == 5);
      tx_ok    = (kind == 1 || kind == 5);
      rx_err   = (kind == 2);
      rx_first = (kind == 3);
      rx_ok    = (kind == 4);
    end
    @(negedge clk);
    {tx_err, tx_ok, rx_err, rx_first, rx_ok} = '0;
  endtask

  task automatic ticks(logic r, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1; brec = r;
    end
    @(negedge clk); tick = 0; brec = 1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 state", state, 0);
    chk("R1 tec", tec, 0);
    chk("R1 rec", rec, 0);
    chk("R1 suspend", susp, 0);
    chk("R6 flag active", flag_rec, 0);
  endtask

  task automatic t_tx_count();
    do_reset();
    pulse(0, 3);  chk("R2 tec +8 x3", tec, 24);
    pulse(1, 25); chk("R2 tec floor 0", tec, 0);
    pulse(5, 1);  chk("R2 err wins", tec, 8);
  endtask

  task automatic t_rx_count();
    do_reset();
    pulse(2, 1);  chk("R3 rec +1", rec, 1);
    pulse(3, 1);  chk("R3 rec +8", rec, 9);
    @(negedge clk); rx_err = 1; rx_first = 1;
    @(negedge clk); rx_err = 0; rx_first = 0;
    chk("R3 first wins", rec, 17);
    pulse(4, 20); chk("R3 rec floor 0", rec, 0);
  endtask

  task automatic t_rx_passive();
    do_reset();
    pulse(3, 15); chk("R4 rec 120 active", state, 0);
    pulse(3, 1);  chk("R4 rec 128 passive", state, 1);
    chk("R6 flag passive", flag_rec, 1);
    pulse(4, 1);  chk("R4 rec 127 active", state, 0);
  endtask

  task automatic t_suspend();
    do_reset();
    pulse(0, 16); chk("R4 tec 128 passive", state, 1);
    chk("R9 no suspend yet", susp, 0);
    pulse(1, 1);  chk("R4 tec 127 active", state, 0);
    chk("R9 suspend set", susp, 1);
    ticks(1, 7);  chk("R9 suspend after 7", susp, 1);
    ticks(1, 1);  chk("R9 suspend after 8", susp, 0);
    pulse(1, 1);  chk("R9 active no suspend", susp, 0);
    chk("R2 tec 126", tec, 126);
  endtask

  task automatic t_busoff();
    do_reset();
    pulse(0, 31); chk("R5 tec 248 passive", state, 1);
    pulse(0, 1);  chk("R5 busoff", state, 2);
    chk("R5 tec 256", tec, 256);
    chk("R9 suspend cleared busoff", susp, 0);
    pulse(1, 1);  chk("R5 tx_ok ignored", tec, 256);
    pulse(3, 1);  chk("R5 rx ignored", rec, 0);
    chk("R6 flag busoff", flag_rec, 1);
    ticks(1, 10); ticks(0, 1);
    ticks(1, 1407);
    chk("R8 dominant restarts run", state, 2);
    ticks(1, 1);
    chk("R7 recovered", state, 0);
    chk("R7 tec cleared", tec, 0);
    chk("R7 rec cleared", rec, 0);
  endtask

  initial begin
    t_reset();
    t_tx_count();
    t_rx_count();
    t_rx_passive();
    t_suspend();
    t_busoff();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #1_500_000;
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule